// File: doc/BRIEF.md
# Compressed Line Decompressor

This block rebuilds a 64-byte memory line from its compressed form. A line is viewed as 32 sub-blocks of 16 bits, sub-block `i` occupying line bits `[16i+15:16i]`. Each compressed line arrives as a 2-bit scheme tag plus a 512-bit packed payload. The tag picks one of four decodings: raw pass-through, zero-map with literals, zero-map with frequent-value codes, or frequent-value codes alone. The block resolves every sub-block at once. A running count over the zero map and over the literal escape codes gives each sub-block the position of its code and of its literal in the payload.

Input and output use valid/ready handshakes. A payload is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its decoded line is presented on `out_valid`/`out_line` from the next edge. A presented line stays unchanged until the edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a sink that holds `out_ready` high sustains one line per clock. The tag and payload are only looked at on the accepting edge.

Top module: `dcmp_top`

## Requirements
- R1: With tag 00 the output line equals the 512-bit payload bit for bit.
- R2: With tag 01, payload bits [31:0] are a zero map (bit i set means sub-block i is zero). The literal for the k-th non-zero sub-block, counting in ascending sub-block order, sits at payload bits starting at 32+16k.
- R3: With tag 01 or 10, every sub-block whose zero-map bit is set comes out as 0x0000, whatever the rest of the payload holds.
- R4: With tag 10 or 11 a 3-bit code is expanded as follows: 001→0x0001, 010→0x0002, 011→0x0004, 100→0x0003, 101→0xFFFF, 110→0x0005, 111→0x0008.
- R5: With tag 10, the code of the j-th non-zero sub-block sits at bit 32+3j. The literal area starts at bit 32+3·NZ, where NZ is the number of clear zero-map bits. Code 000 takes the next unused 16-bit literal from that area, in ascending sub-block order.
- R6: With tag 11 there is no zero map. Sub-block i has its code at bits [3i+2:3i], the literal area starts at bit 96, and a zero sub-block is carried as a 000 code with a 0x0000 literal.
- R7: A literal position at or beyond payload bit 512 reads as zero bits.
- R8: A payload accepted on one edge yields `out_valid` high with its decoded line after that edge. With no new acceptance, `out_valid` falls on the edge that drains it.
- R9: While `out_valid` is high and `out_ready` is low, `out_line` and `out_valid` hold steady and `in_ready` is low.
- R10: During reset `out_valid` is low and `in_ready` is high.
- R11: Any line compressed under a tag whose packed size fits in 512 bits decodes back to the original line bit-exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed line offered |
| in_ready | output | 1 | Block can take a compressed line this cycle |
| in_tag | input | 2 | Scheme tag: 00 raw, 01 zero map, 10 zero map plus codes, 11 codes only |
| in_payload | input | 512 | Packed compressed payload |
| out_valid | output | 1 | Decoded line present |
| out_ready | input | 1 | Sink takes the decoded line this cycle |
| out_line | output | 512 | Decoded 64-byte line, sub-block i at bits [16i+15:16i] |

## Verification
Every sub-block's positions come from a count over all lower sub-blocks. An off-by-one in the non-zero or literal count therefore shifts every later literal, and the damage shows on the first output line whose zero map or code mix reaches that point, one cycle after acceptance. A wrong literal-area base corrupts every escaped sub-block of every tag-10 line. Sweeps vary the number and placement of non-zero sub-blocks, and put every code value in every lane, so that these shifts reach a compared output. A handshake register that takes data while stalled shows up as a changed `out_line` during held back-pressure.

// File: rtl/dcmp_pkg.sv
`timescale 1ns/1ps
package dcmp_pkg;

  localparam int SUB_W  = 16;
  localparam int N_SUB  = 32;
  localparam int CODE_W = 3;
  localparam int LINE_W = SUB_W * N_SUB;

  typedef enum logic [1:0] {
    TAG_RAW  = 2'b00,
    TAG_ZERO = 2'b01,
    TAG_MIX  = 2'b10,
    TAG_FREQ = 2'b11
  } dcmp_tag_e;

  // Expansion of a non-escape frequent-value code.
  function automatic logic [SUB_W-1:0] fv_expand(input logic [CODE_W-1:0] code);
    logic [SUB_W-1:0] v;
    case (code)
      3'd1:    v = 16'h0001;
      3'd2:    v = 16'h0002;
      3'd3:    v = 16'h0004;
      3'd4:    v = 16'h0003;
      3'd5:    v = 16'hFFFF;
      3'd6:    v = 16'h0005;
      3'd7:    v = 16'h0008;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dcmp_slot_index.sv
`timescale 1ns/1ps
// Per-sub-block zero flag, code and literal index by running counts
module dcmp_slot_index
  import dcmp_pkg::*;
#(
  parameter int NS    = N_SUB,
  parameter int CW    = CODE_W,
  parameter int EXT_W = LINE_W + N_SUB * CODE_W + N_SUB,
  parameter int POS_W = $clog2(EXT_W + 1),
  parameter int CNT_W = $clog2(NS + 1)
) (
  input  dcmp_tag_e                    tag,
  input  logic [EXT_W-1:0]             ext,
  output logic [NS-1:0]                is_zero,
  output logic [NS-1:0][CW-1:0]        code,
  output logic [NS-1:0][CNT_W-1:0]     lit_idx,
  output logic [POS_W-1:0]             lit_base
);

  logic [CNT_W-1:0] nz_cnt;
  logic [CNT_W-1:0] lit_cnt;
  logic [POS_W-1:0] code_pos;
  logic             use_map;
  logic             zf;
  logic [CW-1:0]    cd;

  always_comb begin
    nz_cnt   = '0;
    lit_cnt  = '0;
    code_pos = '0;
    is_zero  = '0;
    code     = '0;
    lit_idx  = '0;
    use_map  = (tag == TAG_ZERO) || (tag == TAG_MIX);
    for (int i = 0; i < NS; i++) begin
      zf = use_map && ext[i];
      if (tag == TAG_FREQ)
        code_pos = POS_W'(CW) * POS_W'(i);
      else
        code_pos = POS_W'(NS) + POS_W'(CW) * POS_W'(nz_cnt);
      if (zf || tag == TAG_ZERO || tag == TAG_RAW)
        cd = '0;
      else
        cd = ext[code_pos +: CW];
      is_zero[i] = zf;
      code[i]    = cd;
      lit_idx[i] = lit_cnt;
      if (!zf) begin
        nz_cnt = nz_cnt + 1'b1;
        if (cd == '0)
          lit_cnt = lit_cnt + 1'b1;
      end
    end
    case (tag)
      TAG_MIX:  lit_base = POS_W'(NS) + POS_W'(CW) * POS_W'(nz_cnt);
      TAG_FREQ: lit_base = POS_W'(NS * CW);
      default:  lit_base = POS_W'(NS);
    endcase
  end

endmodule

// File: rtl/dcmp_lane.sv
`timescale 1ns/1ps
// One sub-block: zero, expanded code, or literal fetched from the payload
module dcmp_lane
  import dcmp_pkg::*;
#(
  parameter int SW    = SUB_W,
  parameter int CW    = CODE_W,
  parameter int EXT_W = LINE_W + N_SUB * CODE_W + N_SUB,
  parameter int POS_W = $clog2(EXT_W + 1),
  parameter int CNT_W = $clog2(N_SUB + 1)
) (
  input  logic [EXT_W-1:0] ext,
  input  logic             is_zero,
  input  logic [CW-1:0]    code,
  input  logic [CNT_W-1:0] lit_idx,
  input  logic [POS_W-1:0] lit_base,
  output logic [SW-1:0]    value
);

  logic [POS_W-1:0] lit_pos;

  always_comb begin
    lit_pos = lit_base + POS_W'(SW) * POS_W'(lit_idx);
    if (is_zero)
      value = '0;
    else if (code == '0)
      value = ext[lit_pos +: SW];
    else
      value = SW'(fv_expand(code));
  end

endmodule

// File: rtl/dcmp_out_reg.sv
`timescale 1ns/1ps
// Single-entry output register with valid/ready on both sides
module dcmp_out_reg #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= in_data;
    end
  end

endmodule

// File: rtl/dcmp_top.sv
`timescale 1ns/1ps
module dcmp_top
  import dcmp_pkg::*;
#(
  parameter int NS = N_SUB,
  parameter int SW = SUB_W,
  parameter int CW = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_tag,
  input  logic [NS*SW-1:0]  in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NS*SW-1:0]  out_line
);

  localparam int LW    = NS * SW;
  localparam int EXT_W = LW + NS * CW + NS;
  localparam int POS_W = $clog2(EXT_W + 1);
  localparam int CNT_W = $clog2(NS + 1);

  dcmp_tag_e                  tag;
  logic [EXT_W-1:0]           ext;
  logic [NS-1:0]              is_zero;
  logic [NS-1:0][CW-1:0]      code;
  logic [NS-1:0][CNT_W-1:0]   lit_idx;
  logic [POS_W-1:0]           lit_base;
  logic [LW-1:0]              decoded;
  logic [LW-1:0]              next_line;

  assign tag = dcmp_tag_e'(in_tag);
  // zero padding makes over-range literal reads return zero
  assign ext = {{(EXT_W-LW){1'b0}}, in_payload};

  dcmp_slot_index #(
    .NS(NS), .CW(CW), .EXT_W(EXT_W), .POS_W(POS_W), .CNT_W(CNT_W)
  ) index_i (
    .tag(tag), .ext(ext), .is_zero(is_zero), .code(code),
    .lit_idx(lit_idx), .lit_base(lit_base)
  );

  for (genvar g = 0; g < NS; g++) begin : g_lane
    dcmp_lane #(
      .SW(SW), .CW(CW), .EXT_W(EXT_W), .POS_W(POS_W), .CNT_W(CNT_W)
    ) lane_i (
      .ext(ext), .is_zero(is_zero[g]), .code(code[g]),
      .lit_idx(lit_idx[g]), .lit_base(lit_base),
      .value(decoded[g*SW +: SW])
    );
  end

  assign next_line = (tag == TAG_RAW) ? in_payload : decoded;

  dcmp_out_reg #(.W(LW)) out_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(next_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_line)
  );

endmodule

// File: rtl/dcmp_top_chk.sv
`timescale 1ns/1ps
module dcmp_top_chk #(
  parameter int NS = 32,
  parameter int SW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_tag,
  input logic [NS*SW-1:0] in_payload,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NS*SW-1:0] out_line
);

  logic take;
  assign take = in_valid && in_ready;

  // R1
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_tag == 2'b00 |=> out_line == $past(in_payload));

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_line));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  always @(posedge clk)
    if (!rst_n) reset_ready_chk: assert (in_ready);

  for (genvar g = 0; g < NS; g++) begin : g_zero
    // R3
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && (in_tag == 2'b01 || in_tag == 2'b10) && in_payload[g]
      |=> out_line[g*SW +: SW] == '0);
  end

endmodule

bind dcmp_top dcmp_top_chk #(.NS(NS), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tag(in_tag), .in_payload(in_payload), .out_valid(out_valid),
  .out_ready(out_ready), .out_line(out_line)
);

// File: tb/dcmp_top_tb_top.sv
`timescale 1ns/1ps
module dcmp_top_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_tag = 2'b00;
  logic [511:0] in_payload = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dcmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_payload(in_payload), .out_valid(out_valid),
    .out_ready(out_ready), .out_line(out_line)
  );

  task automatic chk_line(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s line act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s bit act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fv(input int c);
    case (c)
      1: return 16'h0001;  2: return 16'h0002;  3: return 16'h0004;
      4: return 16'h0003;  5: return 16'hFFFF;  6: return 16'h0005;
      7: return 16'h0008;  default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [2:0] code_of(input logic [15:0] v);
    for (int c = 1; c < 8; c++)
      if (fv(c) == v) return 3'(c);
    return 3'd0;
  endfunction

  // Bench model of the packer; bits = payload size needed
  function automatic void pack(input logic [1:0] tag, input logic [511:0] line,
                               output logic [511:0] p, output int bits);
    logic [639:0] b;
    logic [15:0]  v;
    int pos;
    b = '0;
    pos = 0;
    if (tag == 2'b00) begin
      b[511:0] = line;
      pos = 512;
    end else if (tag == 2'b11) begin
      for (int i = 0; i < 32; i++) b[3*i +: 3] = code_of(line[16*i +: 16]);
      pos = 96;
      for (int i = 0; i < 32; i++) begin
        v = line[16*i +: 16];
        if (code_of(v) == 3'd0) begin b[pos +: 16] = v; pos += 16; end
      end
    end else begin
      for (int i = 0; i < 32; i++) b[i] = (line[16*i +: 16] == 16'h0);
      pos = 32;
      if (tag == 2'b10)
        for (int i = 0; i < 32; i++) begin
          v = line[16*i +: 16];
          if (v != 16'h0) begin b[pos +: 3] = code_of(v); pos += 3; end
        end
      for (int i = 0; i < 32; i++) begin
        v = line[16*i +: 16];
        if (v != 16'h0 && (tag == 2'b01 || code_of(v) == 3'd0)) begin
          b[pos +: 16] = v; pos += 16;
        end
      end
    end
    p = b[511:0];
    bits = pos;
  endfunction

  function automatic logic [511:0] mkline(input logic [31:0] mask, input int seed);
    logic [511:0] l;
    int sel;
    l = '0;
    for (int i = 0; i < 32; i++)
      if (mask[i]) begin
        sel = (i * 5 + seed) % 9;
        if (sel < 7) l[16*i +: 16] = fv(sel + 1);
        else         l[16*i +: 16] = {4'h9, 12'(seed * 97 + i * 13)};
      end
    return l;
  endfunction

  task automatic xfer(input logic [1:0] tag, input logic [511:0] p,
                      input logic [511:0] exp, input string req);
    @(negedge clk);
    in_tag = tag; in_payload = p; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit({req, " out_valid"}, out_valid, 1'b1);
    chk_line(req, out_line, exp);
  endtask

  task automatic roundtrip(input logic [1:0] tag, input logic [511:0] line, input string req);
    logic [511:0] p;
    int bits;
    pack(tag, line, p, bits);
    if (bits <= 512) xfer(tag, p, line, req);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [511:0] l, a, b, p;
    logic [31:0]  m;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk_bit("R10 out_valid", out_valid, 1'b0);
    chk_bit("R10 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;

    // R1: raw pass-through
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 16; k++)
        l[32*k +: 32] = (32'(s) * 32'h9E3779B1) ^ (32'(k) * 32'h01000193);
      xfer(2'b00, l, l, "R1");
    end

    // R2 R5 R6 R11: vary count and placement of non-zero sub-blocks
    for (int k = 0; k <= 32; k++)
      for (int s = 0; s < 3; s++) begin
        m = (k == 32) ? 32'hFFFF_FFFF : ((32'h1 << k) - 32'h1);
        m = (m << ((k * 7 + s) % 32)) | (m >> (32 - ((k * 7 + s) % 32)));
        l = mkline(m, s + k);
        roundtrip(2'b01, l, "R2 R11");
        roundtrip(2'b10, l, "R5 R11");
        roundtrip(2'b11, l, "R6 R11");
      end

    // R3 R4: every code value in every lane
    for (int i = 0; i < 32; i++)
      for (int c = 0; c < 8; c++) begin
        l = '0;
        l[16*i +: 16] = (c == 0) ? 16'hBEEF : fv(c);
        roundtrip(2'b10, l, "R3 R4");
        roundtrip(2'b11, l, "R4 R6");
      end

    // R3: zero map wins over garbage in the rest of the payload
    p = {480'h0, 32'hFFFF_FFFF};
    for (int k = 0; k < 15; k++) p[32 + 32*k +: 32] = 32'hDEAD_0000 | 32'(k);
    xfer(2'b10, p, '0, "R3");
    xfer(2'b01, p, '0, "R3");

    // R7: literals past bit 511 read zero
    p = '0;
    l = '0;
    for (int j = 0; j < 26; j++) begin
      p[96 + 16*j +: 16] = 16'hA000 + 16'(j);
      l[16*j +: 16] = 16'hA000 + 16'(j);
    end
    xfer(2'b11, p, l, "R7");

    // R8 R9: back-pressure
    a = mkline(32'h0F0F_F0F0, 5);
    b = mkline(32'h3333_CCCC, 8);
    @(negedge clk);
    in_tag = 2'b00; in_payload = a; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk_bit("R8 valid after accept", out_valid, 1'b1);
    in_payload = b;
    @(negedge clk);
    chk_bit("R9 in_ready low", in_ready, 1'b0);
    chk_line("R9 held line", out_line, a);
    @(negedge clk);
    chk_bit("R9 valid held", out_valid, 1'b1);
    chk_line("R9 held line", out_line, a);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_line("R9 next line", out_line, b);
    @(negedge clk);
    chk_bit("R8 drained", out_valid, 1'b0);

    done = 1'b1;
    summary();
  end

endmodule